// File: doc/BRIEF.md
# Two-Wire Register Slave with Nonvolatile Commit

This block is the serial front end of a small register bank. It sits on a two-wire bus with a clock line and an open-drain data line. It decodes a device identification byte, a register address byte and data bytes. The bank behind it holds four wiper registers, three further locations that exist only in nonvolatile storage, and one access control byte. Wiper values leave the block on a flat output bus so that downstream circuits can use them.

A write frame carries exactly one data byte. The byte lands in a wiper or in the access control byte on the clock fall that ends its last bit. When the access control byte is zero, the STOP that closes a write to a low address starts a nonvolatile commit. The commit lasts a fixed number of system clocks. During it the block is deaf to the bus and keeps the data line released.

Reads use the combined format: a write-style header sets the pointer, then a repeated START and a read identification byte. The slave then streams bytes from the pointer, which advances after each byte. The master paces the stream by acknowledging each byte and ends it with a not-acknowledge. The bus itself is the only data path; there is no valid/ready port.

Both bus lines are sampled and edge-detected in the system clock domain. The bus clock must stay well below a quarter of that rate. The write-permit input is treated as quasi-static.

Top module: `i2c_nvreg_slave`

## Requirements
- R1: The identification byte is sent MSB first as device code 4'b0101 in bits 7..4, the strap value in bits 3..1 and read/not-write in bit 0. A mismatch on either field gets no acknowledge, and the slave stays silent until the next START.
- R2: The register address byte is acknowledged for addresses 0 to 6 and 8 only. Any other address gets no acknowledge.
- R3: When writing is permitted, the data byte is acknowledged. A byte for address 0 to 3 updates that wiper (bits 8*n+7..8*n of the wiper bus), and a byte for address 8 updates the access control byte. The update occurs on the clock fall after the data LSB, before any STOP.
- R4: While the write-permit input is low, the data byte gets no acknowledge. No register changes and no commit follows.
- R5: A STOP that ends an acknowledged write to address 0 to 6, while the access control byte is zero, raises busy for exactly NV_CYCLES system clocks. The byte is stored in the nonvolatile cell of that address.
- R6: While the access control byte is nonzero, no commit starts. Writes to addresses 4 to 6 then change nothing, and wiper writes are volatile only.
- R7: While busy, bus activity is ignored, the data line is released, and no register changes.
- R8: A combined read returns the wiper for addresses 0 to 3, the nonvolatile cell for addresses 4 to 6, and the access control byte for address 8.
- R9: After each byte sent and acknowledged by the master, the pointer advances and the next byte follows; unmapped address 7 reads as zero. A master not-acknowledge ends the stream and leaves the data line released.
- R10: A frame cut by STOP before the data LSB changes nothing. A repeated START after the data byte keeps any wiper update but starts no commit.
- R11: After reset the data line is released, busy is low, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device address straps |
| wr_allow | input | 1 | 1 permits data bytes to be written |
| busy | output | 1 | Nonvolatile commit in progress |
| wipers | output | 32 | Four wiper bytes, wiper n in bits 8n+7..8n |

## Verification
The START handler and the pending-commit decision act in the same cycle whenever a repeated START follows an acknowledged data byte. In that cycle the START must clear the pending write before any STOP can launch a commit. The bench provokes this with a repeated START straight after the data byte for address 5 and again for address 0. It judges the result by busy staying low, the nonvolatile cell keeping its old value, and the wiper holding the new one. A second pairing arises when the commit launch and the end of a frame both come from the same STOP. The bench judges it by counting the busy cycles that start from that STOP edge.

// File: rtl/nvreg_pkg.sv
`timescale 1ns/1ps
package nvreg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEVID,
    PH_REGADR,
    PH_WRDAT,
    PH_RDDAT,
    PH_HOLD
  } phase_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/nvreg_line_sync.sv
`timescale 1ns/1ps
module nvreg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;
  logic              scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  // data edges while the clock line stays high frame a transfer
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/nvreg_bank.sv
`timescale 1ns/1ps
module nvreg_bank #(
  parameter int DW         = 8,
  parameter int AW         = 8,
  parameter int NUM_WIPERS = 4,
  parameter int NV_WORDS   = 7,
  parameter int ACR_ADDR   = 8,
  parameter int NV_CYCLES  = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vol_we,
  input  logic                     nv_go,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     acr_zero,
  output logic                     busy,
  output logic [NUM_WIPERS*DW-1:0] wipers_flat
);
  localparam int CW = $clog2(NV_CYCLES + 1);
  localparam logic [AW-1:0] ACR_AD = AW'(ACR_ADDR);

  logic [DW-1:0] wiper_q [NUM_WIPERS];
  logic [DW-1:0] nv_q    [NV_WORDS];
  logic [DW-1:0] acr_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIPERS; i++) wiper_q[i] <= '0;
      acr_q <= '0;
    end else if (vol_we) begin
      for (int i = 0; i < NUM_WIPERS; i++)
        if (wr_addr == AW'(i)) wiper_q[i] <= wr_data;
      if (wr_addr == ACR_AD) acr_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NV_WORDS; i++) nv_q[i] <= '0;
    end else if (nv_go) begin
      for (int i = 0; i < NV_WORDS; i++)
        if (wr_addr == AW'(i)) nv_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (nv_go)         left_q <= CW'(NV_CYCLES);
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign busy     = (left_q != '0);
  assign acr_zero = (acr_q == '0);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NV_WORDS; i++)
      if (rd_addr == AW'(i)) rd_data = nv_q[i];
    for (int i = 0; i < NUM_WIPERS; i++)
      if (rd_addr == AW'(i)) rd_data = wiper_q[i];
    if (rd_addr == ACR_AD) rd_data = acr_q;
  end

  for (genvar gi = 0; gi < NUM_WIPERS; gi++) begin : g_wiper_out
    assign wipers_flat[gi*DW +: DW] = wiper_q[gi];
  end

  assert_commit_raises_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_go |=> busy);

  assert_wipers_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wipers_flat));
endmodule

// File: rtl/i2c_nvreg_slave.sv
`timescale 1ns/1ps
module i2c_nvreg_slave
  import nvreg_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'b0101,
  parameter int         NV_CYCLES   = 1000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic [2:0]  strap,
  input  logic        wr_allow,
  output logic        busy,
  output logic [31:0] wipers
);
  localparam int AW         = BYTE_W;
  localparam int NUM_WIPERS = 4;
  localparam int NV_WORDS   = 7;
  localparam int ACR_ADDR   = 8;
  localparam logic [AW-1:0] NV_LIM = AW'(NV_WORDS);
  localparam logic [AW-1:0] WP_LIM = AW'(NUM_WIPERS);
  localparam logic [AW-1:0] ACR_AD = AW'(ACR_ADDR);

  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  phase_t            phase;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [AW-1:0]     ptr;
  logic              ack_drv;
  logic              tx_on;
  logic              pend;

  logic              id_ok, addr_ok, byte_ok;
  logic              vol_we, nv_go, acr_zero;
  logic [BYTE_W-1:0] rd_data;

  nvreg_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  nvreg_bank #(
    .DW(BYTE_W), .AW(AW), .NUM_WIPERS(NUM_WIPERS), .NV_WORDS(NV_WORDS),
    .ACR_ADDR(ACR_ADDR), .NV_CYCLES(NV_CYCLES)
  ) bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .vol_we      (vol_we),
    .nv_go       (nv_go),
    .wr_addr     (ptr),
    .wr_data     (rx_sh),
    .rd_addr     (ptr),
    .rd_data     (rd_data),
    .acr_zero    (acr_zero),
    .busy        (busy),
    .wipers_flat (wipers)
  );

  assign id_ok   = (rx_sh[7:4] == DEV_CODE) && (rx_sh[3:1] == strap);
  assign addr_ok = (rx_sh < NV_LIM) || (rx_sh == ACR_AD);

  always_comb begin
    case (phase)
      PH_DEVID:  byte_ok = id_ok;
      PH_REGADR: byte_ok = addr_ok;
      PH_WRDAT:  byte_ok = wr_allow;
      default:   byte_ok = 1'b0;
    endcase
  end

  // volatile copy on the clock fall that closes the data LSB
  assign vol_we = !busy && !start_ev && !stop_ev && (phase == PH_WRDAT) &&
                  scl_fall && (cnt == 4'd8) && wr_allow &&
                  ((ptr < WP_LIM) || (ptr == ACR_AD));

  assign nv_go = !busy && stop_ev && pend && (ptr < NV_LIM) && acr_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      ack_drv <= 1'b0;
      tx_on   <= 1'b0;
      pend    <= 1'b0;
    end else if (busy) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      ack_drv <= 1'b0;
      tx_on   <= 1'b0;
      pend    <= 1'b0;
    end else if (start_ev) begin
      phase   <= PH_DEVID;
      cnt     <= '0;
      ack_drv <= 1'b0;
      tx_on   <= 1'b0;
      pend    <= 1'b0;
    end else if (stop_ev) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      ack_drv <= 1'b0;
      tx_on   <= 1'b0;
      pend    <= 1'b0;
    end else begin
      case (phase)
        PH_DEVID, PH_REGADR, PH_WRDAT: begin
          if (scl_rise && cnt < 4'd8) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (byte_ok) begin
              ack_drv <= 1'b1;
              cnt     <= 4'd9;
            end else begin
              phase <= PH_HOLD;
            end
            if (phase == PH_REGADR && addr_ok) ptr  <= rx_sh;
            if (phase == PH_WRDAT && wr_allow) pend <= 1'b1;
          end else if (scl_fall && cnt == 4'd9) begin
            ack_drv <= 1'b0;
            cnt     <= '0;
            case (phase)
              PH_DEVID: begin
                if (rx_sh[0]) begin
                  phase <= PH_RDDAT;
                  tx_sh <= rd_data;
                  ptr   <= ptr + 1'b1;
                  tx_on <= 1'b1;
                end else begin
                  phase <= PH_REGADR;
                end
              end
              PH_REGADR: phase <= PH_WRDAT;
              default:   phase <= PH_HOLD;
            endcase
          end
        end
        PH_RDDAT: begin
          if (scl_rise) begin
            if (cnt < 4'd8) cnt <= cnt + 1'b1;
            else if (cnt == 4'd8) begin
              if (sda_lvl) phase <= PH_HOLD;
              else         cnt   <= 4'd9;
            end
          end else if (scl_fall) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end else if (cnt == 4'd8) begin
              tx_on <= 1'b0;
            end else if (cnt == 4'd9) begin
              tx_sh <= rd_data;
              ptr   <= ptr + 1'b1;
              tx_on <= 1'b1;
              cnt   <= '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = !busy && (ack_drv || (tx_on && !tx_sh[BYTE_W-1]));

  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  assert_deaf_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (phase == PH_IDLE && !ack_drv && !tx_on));

  assert_ack_not_during_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drv |-> !tx_on);
endmodule

// File: tb/i2c_nvreg_slave_tb.sv
`timescale 1ns/1ps
module i2c_nvreg_slave_tb_top;
  localparam int         Q    = 8;
  localparam int         NVC  = 1000;
  localparam logic [3:0] CODE = 4'b0101;
  localparam logic [2:0] STRP = 3'b010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        wr_allow = 1'b1;
  logic        sda_oe, busy;
  logic [31:0] wipers;
  logic        sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_nvreg_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_m),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .strap    (STRP),
    .wr_allow (wr_allow),
    .busy     (busy),
    .wipers   (wipers)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;
  logic [7:0] mem [0:8];

  // {addr, data, allow, expect data ack, expect commit}
  localparam logic [18:0] VEC [9] = '{
    {8'd0, 8'h5A, 1'b1, 1'b1, 1'b1},
    {8'd3, 8'hC3, 1'b1, 1'b1, 1'b1},
    {8'd5, 8'h77, 1'b1, 1'b1, 1'b1},
    {8'd1, 8'h11, 1'b0, 1'b0, 1'b0},
    {8'd8, 8'h01, 1'b1, 1'b1, 1'b0},
    {8'd2, 8'h99, 1'b1, 1'b1, 1'b0},
    {8'd6, 8'h44, 1'b1, 1'b1, 1'b0},
    {8'd8, 8'h00, 1'b1, 1'b1, 1'b0},
    {8'd6, 8'h44, 1'b1, 1'b1, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop(input int tail);
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(tail);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); d[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1;
    tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_frame(input logic [7:0] a, input logic [7:0] d, output bit k3);
    bit k;
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k); check("R1", "write id ack", k, 1);
    send_byte(a, k);                  check("R2", "write addr ack", k, 1);
    send_byte(d, k3);
    bus_stop(Q);
  endtask

  task automatic rd_frame(input logic [7:0] a, output logic [7:0] d);
    bit k;
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(a, k);
    bus_rstart();
    send_byte({CODE, STRP, 1'b1}, k); check("R8", "read id ack", k, 1);
    recv_byte(1'b0, d);
    bus_stop(Q);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3*NVC) begin tick(1); n++; end
    tick(Q);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    bit k;
    int n;
    for (int i = 0; i <= 8; i++) mem[i] = 8'h00;
    tick(5); rst_n = 1'b1; tick(5);

    // R11: reset state
    check("R11", "sda_oe after reset", sda_oe, 0);
    check("R11", "busy after reset", busy, 0);
    check("R11", "wipers after reset", wipers, 0);
    rd_frame(8'd8, d); check("R11", "control byte after reset", d, 0);
    rd_frame(8'd4, d); check("R11", "nv cell 4 after reset", d, 0);

    // table of write frames, each followed by a read back
    foreach (VEC[v]) begin
      logic [7:0] a, dat;
      bit al, eack, env;
      {a, dat, al, eack, env} = VEC[v];
      wr_allow = al;
      wr_frame(a, dat, k);
      check(al ? "R3" : "R4", "data byte ack", k, eack);
      check(env ? "R5" : "R6", "busy after stop", busy, env);
      wait_idle();
      wr_allow = 1'b1;
      if (al) begin
        if (a < 4 || a == 8) mem[a] = dat;
        else if (a <= 6 && mem[8] == 8'h00) mem[a] = dat;
      end
      rd_frame(a, d);
      check("R8", "read back", d, mem[a]);
      if (a < 4) check("R3", "wiper port", wipers[8*a +: 8], mem[a]);
    end

    // R1: identification mismatches
    bus_start();
    send_byte({CODE, 3'b000, 1'b0}, k); check("R1", "strap mismatch ack", k, 0);
    send_byte(8'h00, k);                check("R1", "silent after mismatch", k, 0);
    bus_stop(Q);
    bus_start();
    send_byte({4'b1010, STRP, 1'b0}, k); check("R1", "code mismatch ack", k, 0);
    bus_stop(Q);

    // R2: unmapped addresses
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(8'd7, k); check("R2", "addr 7 ack", k, 0);
    bus_stop(Q);
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(8'd9, k); check("R2", "addr 9 ack", k, 0);
    bus_stop(Q);

    // R9: sequential read from 3 through unmapped 7
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(8'd3, k);
    bus_rstart();
    send_byte({CODE, STRP, 1'b1}, k);
    for (int j = 3; j <= 7; j++) begin
      recv_byte(j != 7, d);
      check("R9", "sequential byte", d, (j == 7) ? 0 : mem[j]);
    end
    tick(Q);
    check("R9", "line released after nack", sda_line, 1);
    bus_stop(Q);

    // R7: bus ignored during commit
    wr_frame(8'd4, 8'h21, k); mem[4] = 8'h21;
    check("R5", "busy after nv write", busy, 1);
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k); check("R7", "id ack while busy", k, 0);
    check("R7", "still busy", busy, 1);
    check("R7", "sda released while busy", sda_oe, 0);
    bus_stop(Q);
    wait_idle();
    rd_frame(8'd4, d); check("R5", "nv cell 4 stored", d, 8'h21);

    // R5: exact busy length, counted from the STOP edge
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(8'd5, k);
    send_byte(8'h3C, k);
    bus_stop(0);
    n = 0;
    for (int c = 0; c < NVC + 60; c++) begin tick(1); if (busy) n++; end
    check("R5", "busy cycle count", n, NVC);
    mem[5] = 8'h3C;
    tick(Q);

    // R10: abort before data LSB
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(8'd1, k);
    send_bits(8'hF0, 4);
    bus_stop(Q);
    check("R10", "busy after abort", busy, 0);
    check("R10", "wiper 1 after abort", wipers[15:8], mem[1]);

    // R10: repeated START after data to address 5 -> no commit
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(8'd5, k);
    send_byte(8'hEE, k); check("R10", "data ack before rstart", k, 1);
    bus_rstart();
    send_byte({CODE, STRP, 1'b1}, k);
    recv_byte(1'b0, d);
    bus_stop(Q);
    check("R10", "nv cell 5 unchanged", d, mem[5]);
    check("R10", "no busy after rstart frame", busy, 0);

    // R10/R3: repeated START after wiper data keeps volatile value only
    bus_start();
    send_byte({CODE, STRP, 1'b0}, k);
    send_byte(8'd0, k);
    send_byte(8'h0F, k);
    check("R3", "wiper 0 before stop", wipers[7:0], 8'h0F);
    bus_rstart();
    send_byte({CODE, STRP, 1'b1}, k);
    recv_byte(1'b0, d);
    bus_stop(Q);
    check("R10", "wiper 0 read after rstart", d, 8'h0F);
    check("R10", "no commit after wiper rstart", busy, 0);

    finish_run();
  end
endmodule